// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block drains a circular list of transmit descriptors that software places in host memory. Each entry is 16 bytes. Software tells the block where the list starts, how many bytes it covers and which index it has filled up to (the tail). While transmission is enabled and the head index differs from the tail, the block takes the next descriptor. It fetches the four words of the descriptor, then reads the data buffer the descriptor points at, one aligned 32-bit word at a time. The buffer bytes leave on a byte stream with a valid/ready handshake.

A descriptor can ask for a completion report. In that case the block writes the status word back with its done bit set and raises a write-back cause. The head index advances after every descriptor and wraps at the end of the ring. A run stops after a descriptor that closes a packet, or earlier if the head reaches the tail. Whenever the head meets the tail at the end of a run, a queue-empty cause is raised. Both causes are sticky and stay set until they are cleared.

Top module: `tx_ring_fetch`

## Requirements
- R1: After reset the head index is 0, both cause bits are 0, and neither a memory request nor packet data is presented.
- R2: While `txEnable` is low, the block starts no descriptor. No memory request appears and the head index does not move, even when the tail differs from the head.
- R3: When the head index equals `tailIdx`, no memory request is issued.
- R4: A descriptor at index h is fetched as four 32-bit reads at `ringBase + 16*h + 0, 4, 8, 12`.
- R5: The buffer address is word1 (upper half) concatenated with word0 (lower half). Its two low bits are ignored. The byte count is word2 bits [15:0]. Word2 bits [23:16] have no effect on the output. The buffer is read with aligned word reads, and no word beyond the one that holds the last byte is read. Exactly the counted bytes are output in ascending address order, with byte k of each word taken from bits [8k+7:8k]. A descriptor with a count of zero outputs nothing.
- R6: When word2 bit 27 (report status) is set, word3 with bit 0 set is written to `ringBase + 16*h + 12` after the buffer has been sent, and cause bit 0 is raised.
- R7: When word2 bit 27 is clear, no write is issued for that descriptor.
- R8: After each descriptor the head index increments. It becomes 0 when the incremented value equals `ringLenBytes/16`.
- R9: When word2 bit 24 (end of packet) is set, `pktLast` accompanies the descriptor's final byte. The run then ends, even if further descriptors are pending. Any later descriptor is only taken as a new run.
- R10: Cause bit 1 (queue empty) is raised when the head equals the tail after a descriptor. It is not raised when a run ends with descriptors still pending.
- R11: Cause bits are sticky and clear only in the cycle after a one is presented on the matching `causeClr` bit.
- R12: A memory request holds its valid, write flag and address until it is accepted. The block waits for the read response before it continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Allows new descriptors to be taken |
| ringBase | input | 64 | Byte address of ring entry 0 |
| ringLenBytes | input | IDX_W+4 | Ring size in bytes (multiple of 16) |
| tailIdx | input | IDX_W | Index one past the last filled descriptor |
| causeClr | input | 2 | Write-one-to-clear for the cause bits |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 for a write, 0 for a read |
| memReqAddr | output | 64 | Byte address of the word |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read response present |
| memRspData | input | 32 | Read response word |
| headIdx | output | IDX_W | Current head index |
| pktValid | output | 1 | Packet byte present |
| pktReady | input | 1 | Sink accepts the byte |
| pktData | output | 8 | Packet byte |
| pktLast | output | 1 | Final byte of a packet |
| irqCause | output | 2 | Bit 0 write-back done, bit 1 queue empty |

## Verification
A wrong head index appears at the ports within a few cycles of the next request, as a fetch from the wrong descriptor address. That fetch brings in wrong bytes or misplaces write-backs, and the scoreboard catches both on the first affected transfer. A wrong byte offset or captured length shows up on the very next output byte as a data, order or `pktLast` mismatch, or as a read of an unmapped word. The memory model stalls the block after an end-of-packet descriptor, which exposes a stale head or a spurious queue-empty cause while the block waits.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int ADDR_W   = 64;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int EOP_BIT  = 24;
  localparam int RS_BIT   = 27;
  localparam int DD_BIT   = 0;
  localparam int CAUSE_WB = 0;
  localparam int CAUSE_QE = 1;

  typedef enum logic [1:0] {ADDR_DESC, ADDR_BUF, ADDR_WB} addrSel_e;

  typedef struct packed {
    logic     startDesc;
    logic     captureDesc;
    logic     captureBuf;
    logic     byteSent;
    logic     advanceHead;
    logic     setWb;
    logic     setQe;
    addrSel_e addrSel;
  } strobe_t;

  typedef struct packed {
    logic ringEmpty;
    logic descLast;
    logic lenZero;
    logic lastByte;
    logic wordEnd;
    logic rsBit;
    logic eopBit;
    logic hitTail;
  } status_t;
endpackage

// File: rtl/tx_ring_dp.sv
module tx_ring_dp
  import tx_ring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [IDX_W+3:0]  ringLenBytes,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [1:0]        causeClr,
  input  logic [WORD_W-1:0] memRspData,
  output status_t           st,
  output logic [IDX_W-1:0]  headIdx,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqWdata,
  output logic [7:0]        pktData,
  output logic              pktLastRaw,
  output logic [1:0]        irqCause
);
  localparam int RLEN_W = IDX_W + 4;

  logic [IDX_W-1:0]  headQ, nextHead;
  logic [IDX_W:0]    headInc;
  logic [1:0]        wordCnt;
  logic [ADDR_W-1:2] bufAddrQ;
  logic [LEN_W-1:0]  lenQ, byteOff;
  logic [LEN_W:0]    sentNext;
  logic              eopQ, rsQ;
  logic [WORD_W-1:0] statusQ, bufWord;
  logic [1:0]        causeQ;
  logic [ADDR_W-1:0] descAddr;

  assign headInc  = {1'b0, headQ} + 1'b1;
  assign nextHead = (RLEN_W'(headInc) == (ringLenBytes >> 4)) ? '0 : headInc[IDX_W-1:0];
  assign descAddr = ringBase + ADDR_W'({headQ, 4'b0000});
  assign sentNext = {1'b0, byteOff} + 1'b1;

  always_comb begin
    st.ringEmpty = (headQ == tailIdx);
    st.descLast  = (wordCnt == 2'd3);
    st.lenZero   = (lenQ == '0);
    st.lastByte  = (sentNext == {1'b0, lenQ});
    st.wordEnd   = (byteOff[1:0] == 2'b11) || st.lastByte;
    st.rsBit     = rsQ;
    st.eopBit    = eopQ;
    st.hitTail   = (nextHead == tailIdx);
  end

  always_comb begin
    case (stb.addrSel)
      ADDR_BUF: memReqAddr = {bufAddrQ, 2'b00} + ADDR_W'(byteOff);
      ADDR_WB:  memReqAddr = descAddr + ADDR_W'(12);
      default:  memReqAddr = descAddr + ADDR_W'({wordCnt, 2'b00});
    endcase
  end

  assign memReqWdata = statusQ | (WORD_W'(1) << DD_BIT);
  assign pktData     = bufWord[8*byteOff[1:0] +: 8];
  assign pktLastRaw  = eopQ && st.lastByte;
  assign headIdx     = headQ;
  assign irqCause    = causeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ    <= '0;
      wordCnt  <= '0;
      bufAddrQ <= '0;
      lenQ     <= '0;
      byteOff  <= '0;
      eopQ     <= 1'b0;
      rsQ      <= 1'b0;
      statusQ  <= '0;
      bufWord  <= '0;
      causeQ   <= '0;
    end else begin
      if (stb.startDesc) begin
        wordCnt <= '0;
        byteOff <= '0;
      end
      if (stb.captureDesc) begin
        wordCnt <= wordCnt + 1'b1;
        case (wordCnt)
          2'd0: bufAddrQ[31:2]  <= memRspData[31:2];
          2'd1: bufAddrQ[63:32] <= memRspData;
          2'd2: begin
            lenQ <= memRspData[LEN_W-1:0];
            eopQ <= memRspData[EOP_BIT];
            rsQ  <= memRspData[RS_BIT];
          end
          default: statusQ <= memRspData;
        endcase
      end
      if (stb.captureBuf)  bufWord <= memRspData;
      if (stb.byteSent)    byteOff <= byteOff + 1'b1;
      if (stb.advanceHead) headQ   <= nextHead;
      causeQ[CAUSE_WB] <= (causeQ[CAUSE_WB] & ~causeClr[CAUSE_WB]) | stb.setWb;
      causeQ[CAUSE_QE] <= (causeQ[CAUSE_QE] & ~causeClr[CAUSE_QE]) | stb.setQe;
    end
  end

  // R8: the head only steps by one or returns to zero
  assert_head_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (headQ != $past(headQ)) |-> (headQ == '0 || headQ == $past(headQ) + 1'b1));

  // R11: a cause bit drops only after its clear input was high
  assert_cause_sticky_wb_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(causeQ[CAUSE_WB]) |-> $past(causeClr[CAUSE_WB]));
  assert_cause_sticky_qe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(causeQ[CAUSE_QE]) |-> $past(causeClr[CAUSE_QE]));
endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
  import tx_ring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txEnable,
  input  status_t st,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    pktReady,
  output strobe_t stb,
  output logic    memReqValid,
  output logic    memReqWrite,
  output logic    pktValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_BREQ, S_BWAIT, S_STREAM, S_WB, S_ADV
  } state_e;

  state_e state, nxt;

  always_comb begin
    stb         = '0;
    stb.addrSel = ADDR_DESC;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    pktValid    = 1'b0;
    nxt         = state;
    case (state)
      S_IDLE: if (txEnable && !st.ringEmpty) begin
        stb.startDesc = 1'b1;
        nxt = S_DREQ;
      end
      S_DREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_DWAIT;
      end
      S_DWAIT: if (memRspValid) begin
        stb.captureDesc = 1'b1;
        if (!st.descLast)     nxt = S_DREQ;
        else if (!st.lenZero) nxt = S_BREQ;
        else                  nxt = st.rsBit ? S_WB : S_ADV;
      end
      S_BREQ: begin
        stb.addrSel = ADDR_BUF;
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_BWAIT;
      end
      S_BWAIT: begin
        stb.addrSel = ADDR_BUF;
        if (memRspValid) begin
          stb.captureBuf = 1'b1;
          nxt = S_STREAM;
        end
      end
      S_STREAM: begin
        stb.addrSel = ADDR_BUF;
        pktValid = 1'b1;
        if (pktReady) begin
          stb.byteSent = 1'b1;
          if (st.lastByte)     nxt = st.rsBit ? S_WB : S_ADV;
          else if (st.wordEnd) nxt = S_BREQ;
        end
      end
      S_WB: begin
        stb.addrSel = ADDR_WB;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          stb.setWb = 1'b1;
          nxt = S_ADV;
        end
      end
      default: begin
        stb.advanceHead = 1'b1;
        if (st.eopBit || st.hitTail) begin
          stb.setQe = st.hitTail;
          nxt = S_IDLE;
        end else begin
          stb.startDesc = 1'b1;
          nxt = S_DREQ;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  // R2: a disabled idle block stays idle
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !txEnable) |=> (state == S_IDLE));

  // R3: an empty ring issues no request
  assert_empty_no_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && st.ringEmpty) |=> !memReqValid);

  // R12: a pending request keeps its valid and direction
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite)));

  // R5: a stalled byte stays offered
  assert_pkt_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> pktValid);
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch
  import tx_ring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [IDX_W+3:0]  ringLenBytes,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [1:0]        causeClr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic [IDX_W-1:0]  headIdx,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [7:0]        pktData,
  output logic              pktLast,
  output logic [1:0]        irqCause
);
  strobe_t stb;
  status_t st;
  logic    pktLastRaw;

  tx_ring_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .st(st),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .pktReady(pktReady),
    .stb(stb), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .pktValid(pktValid)
  );

  tx_ring_dp #(.IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ringBase(ringBase),
    .ringLenBytes(ringLenBytes), .tailIdx(tailIdx), .causeClr(causeClr),
    .memRspData(memRspData), .st(st), .headIdx(headIdx),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .pktData(pktData),
    .pktLastRaw(pktLastRaw), .irqCause(irqCause)
  );

  assign pktLast = pktValid && pktLastRaw;

  // R12: address of a pending request does not move
  assert_addr_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

  // R9: a stalled byte keeps its data and last flag
  assert_pkt_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> ($stable(pktData) && $stable(pktLast)));
endmodule

// File: tb/tx_ring_fetch_tb_top.sv
`timescale 1ns/1ps
module tx_ring_fetch_tb_top;
  localparam int IDX_W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN, txEnable;
  logic [63:0]       ringBase;
  logic [IDX_W+3:0]  ringLenBytes;
  logic [IDX_W-1:0]  tailIdx;
  logic [1:0]        causeClr;
  logic              memReqValid, memReqReady, memReqWrite;
  logic [63:0]       memReqAddr;
  logic [31:0]       memReqWdata;
  logic              memRspValid;
  logic [31:0]       memRspData;
  logic [IDX_W-1:0]  headIdx;
  logic              pktValid, pktReady, pktLast;
  logic [7:0]        pktData;
  logic [1:0]        irqCause;

  tx_ring_fetch #(.IDX_W(IDX_W)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [logic [61:0]];
  logic [9:0]  expPkt [$];
  logic [95:0] expWr [$];
  int          reqCount = 0;
  logic        stallMem = 1'b0;
  int          rspWait = 0;
  logic        rspPending = 1'b0;
  logic [31:0] rspHold = '0;
  logic [15:0] lfsr = 16'hACE1;
  localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putDesc(input int idx, input logic [63:0] bufA, input int len,
                         input bit eop, input bit rs, input logic [7:0] seed, input bit stallAt);
    logic [63:0] d;
    logic [31:0] w2, w3;
    d  = BASE + 64'(idx * 16);
    w3 = 32'hA5C3_0000 | 32'(idx << 4);
    w2 = 32'(len) | 32'h00AB_0000 | (32'(eop) << 24) | (32'(rs) << 27);
    mem[d[63:2]]         = bufA[31:0];
    mem[d[63:2] + 62'd1] = bufA[63:32];
    mem[d[63:2] + 62'd2] = w2;
    mem[d[63:2] + 62'd3] = w3;
    for (int wi = 0; wi < (len + 3) / 4; wi++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[8*b +: 8] = seed + 8'(wi * 4 + b);
      mem[bufA[63:2] + 62'(wi)] = w;
    end
    for (int i = 0; i < len; i++)
      expPkt.push_back({stallAt && (i == len - 1), eop && (i == len - 1), seed + 8'(i)});
    if (rs) expWr.push_back({d + 64'd12, w3 | 32'h1});
  endtask

  // memory model and packet monitor, all at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rstN) begin
      memReqReady = 1'b0; memRspValid = 1'b0; pktReady = 1'b0; rspPending = 1'b0;
    end else begin
      memRspValid = 1'b0;
      if (rspPending) begin
        rspWait--;
        if (rspWait == 0) begin
          memRspValid = 1'b1; memRspData = rspHold; rspPending = 1'b0;
        end
      end
      memReqReady = !stallMem && (lfsr[0] || lfsr[3]);
      if (memReqValid && memReqReady) begin
        reqCount++;
        if (memReqWrite) begin
          if (expWr.size() == 0) chk(0, "R7 unexpected write", {memReqAddr, memReqWdata}, 0);
          else begin
            logic [95:0] e;
            e = expWr.pop_front();
            chk({memReqAddr, memReqWdata} == e, "R6 write-back", {memReqAddr, memReqWdata}, e);
          end
          mem[memReqAddr[63:2]] = memReqWdata;
        end else begin
          chk(memReqAddr[1:0] == 2'b00, "R5 aligned read", memReqAddr, 0);
          if (!mem.exists(memReqAddr[63:2])) begin
            chk(0, "R4 R5 read of unmapped word", memReqAddr, 0);
            rspHold = 32'hDEAD_BEEF;
          end else rspHold = mem[memReqAddr[63:2]];
          rspPending = 1'b1;
          rspWait = 1 + int'(lfsr[5:4] % 3);
        end
      end
      pktReady = lfsr[1] || lfsr[7];
      if (pktValid && pktReady) begin
        if (expPkt.size() == 0) chk(0, "R5 unexpected byte", {pktLast, pktData}, 0);
        else begin
          logic [9:0] e;
          e = expPkt.pop_front();
          chk({pktLast, pktData} == e[8:0], "R5 R9 packet byte", {pktLast, pktData}, e[8:0]);
          if (e[9]) stallMem = 1'b1;
        end
      end
    end
  end

  task automatic waitDone(input int target);
    int n;
    n = 0;
    while (!(expPkt.size() == 0 && expWr.size() == 0 && int'(headIdx) == target &&
             !memReqValid && !pktValid && !rspPending) && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(n < 5000, "R9 run completes", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic clearCauses();
    @(negedge clk); causeClr = 2'b11;
    @(negedge clk); causeClr = 2'b00;
    chk(irqCause == 2'b00, "R11 causes cleared", irqCause, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    rstN = 1'b0; txEnable = 1'b0; ringBase = BASE; ringLenBytes = 16'd128;
    tailIdx = '0; causeClr = 2'b00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(headIdx == 0, "R1 head after reset", headIdx, 0);
    chk(irqCause == 0, "R1 causes after reset", irqCause, 0);
    chk(!memReqValid && !pktValid, "R1 idle outputs", {memReqValid, pktValid}, 0);

    // two-descriptor packet, disabled at first
    putDesc(0, 64'h0000_0001_0000_2000, 5, 0, 0, 8'h10, 0);
    putDesc(1, 64'h0000_0000_0000_3000, 7, 1, 1, 8'h40, 0);
    tailIdx = 12'd2;
    repeat (40) @(negedge clk);
    chk(reqCount == 0, "R2 no request while disabled", reqCount, 0);
    chk(headIdx == 0, "R2 head frozen while disabled", headIdx, 0);
    txEnable = 1'b1;
    waitDone(2);
    chk(headIdx == 2, "R8 head after run", headIdx, 2);
    chk(irqCause == 2'b11, "R6 R10 causes after run", irqCause, 2'b11);

    rc = reqCount;
    repeat (30) @(negedge clk);
    chk(reqCount == rc, "R3 empty ring stays quiet", reqCount, rc);
    clearCauses();

    // end of packet with a descriptor pending; memory stalls afterwards
    putDesc(2, 64'h0000_0000_0000_4000, 4, 1, 0, 8'h70, 1);
    putDesc(3, 64'h0000_0000_0000_5000, 3, 1, 1, 8'h90, 0);
    tailIdx = 12'd4;
    begin
      int n;
      n = 0;
      while (!stallMem && n < 5000) begin @(negedge clk); n++; end
    end
    repeat (20) @(negedge clk);
    chk(headIdx == 3, "R9 run stopped after end of packet", headIdx, 3);
    chk(irqCause[1] == 1'b0, "R10 no queue-empty with work pending", irqCause, 0);
    chk(memReqValid && !memReqWrite, "R12 request held during stall", {memReqValid, memReqWrite}, 2'b10);
    stallMem = 1'b0;
    waitDone(4);
    chk(irqCause == 2'b11, "R6 R10 causes after second run", irqCause, 2'b11);
    clearCauses();

    // wrap around the ring, zero-length descriptor with write-back
    putDesc(4, 64'h0000_0000_0000_6000, 1, 1, 0, 8'hA0, 0);
    putDesc(5, 64'h0000_0000_0000_7000, 8, 0, 0, 8'hB0, 0);
    putDesc(6, 64'h0000_0000_0000_7800, 0, 0, 1, 8'h00, 0);
    putDesc(7, 64'h0000_0000_0000_8000, 2, 0, 0, 8'hC0, 0);
    putDesc(0, 64'h0000_0002_0000_9000, 3, 1, 1, 8'hD0, 0);
    putDesc(1, 64'h0000_0000_0000_A000, 6, 1, 0, 8'hE0, 0);
    tailIdx = 12'd2;
    waitDone(2);
    chk(headIdx == 2, "R8 head after wrap", headIdx, 2);
    chk(irqCause == 2'b11, "R6 R10 causes after wrap", irqCause, 2'b11);
    clearCauses();

    // disable again with work posted
    txEnable = 1'b0;
    putDesc(2, 64'h0000_0000_0000_B000, 2, 1, 1, 8'hF0, 0);
    tailIdx = 12'd3;
    rc = reqCount;
    repeat (40) @(negedge clk);
    chk(reqCount == rc, "R2 disabled with work posted", reqCount, rc);
    chk(headIdx == 2, "R2 head unchanged", headIdx, 2);
    txEnable = 1'b1;
    waitDone(3);
    chk(irqCause == 2'b11, "R6 R10 causes after last run", irqCause, 2'b11);

    chk(expPkt.size() == 0, "R5 all bytes seen", expPkt.size(), 0);
    chk(expWr.size() == 0, "R6 all write-backs seen", expWr.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule